// File: doc/BRIEF.md
# Daisy-Chain Priority Interrupt Arbiter

This block settles simultaneous interrupt requests from several devices by their position in a serial chain. Each device owns one identical cell. A request pulse from a device is held in its cell as a pending flag. All pending flags together drive a single active-low request line toward the processor: the line is low while any device is pending and high otherwise.

The processor answers with an acknowledge. The acknowledge enters the first cell of the chain as its priority input. A cell that is not pending hands the acknowledge on to the next cell through its priority output. The first pending cell it reaches keeps it and blocks every cell further down. That cell puts its interrupt vector on the vector bus, raises its own grant output and drops its pending flag. The next acknowledge then reaches the next pending device in chain order. Cell 0 sits at the head of the chain and has the highest priority. If an acknowledge passes the last cell without being claimed, it appears on a separate output, so that a further chain can be attached there.

All outputs are registered and change on the clock edge that samples the acknowledge. The processor should raise the acknowledge for one cycle for each interrupt it wants to service.

Top module: `irq_daisy_arbiter`

## Requirements
- R1: While reset is high, and on the first edge after it, the request line reads 1 and grant, vector valid, vector and unclaimed all read 0. Reset also clears every pending flag, so an acknowledge given right after reset finds no device.
- R2: A device request that is high at a clock edge sets that device's pending flag. The request line goes low from that same edge on and stays low while any flag is set.
- R3: The request line returns to 1 on the edge where the last pending flag is cleared.
- R4: At an edge where the acknowledge is high, the pending device with the lowest index wins. Index 0 is the head of the chain. After that edge exactly that device's bit of grant is 1, and the grant is one-hot.
- R5: With the default parameters, the winner's vector is 0x40 plus its index. The vector is shown with vector valid at 1. In a cycle with no grant, the vector reads 0 and vector valid reads 0.
- R6: Each grant clears the winner's pending flag. Repeated single-cycle acknowledges therefore serve the pending devices one at a time in ascending index order.
- R7: If a device requests again in the same cycle in which it is granted, its pending flag stays set and it is served again by a later acknowledge.
- R8: An acknowledge that finds no pending device grants nothing and raises unclaimed for that one cycle.
- R9: A request arriving in the same cycle as an acknowledge does not take part in that acknowledge, even from a higher-priority device. It is served by a later one.
- R10: Without an acknowledge, grant stays 0 and no pending flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_req_i | input | N_DEV | Per-device request pulses; bit 0 has the highest priority |
| ack_i | input | 1 | Processor acknowledge; feeds the priority input of cell 0 |
| irq_n_o | output | 1 | Shared active-low request line |
| grant_o | output | N_DEV | One-hot grant, one bit per device |
| vec_o | output | VEC_W | Vector of the granted device, 0 when idle |
| vec_valid_o | output | 1 | High when vec_o carries a granted vector |
| unclaimed_o | output | 1 | Acknowledge passed the last cell without a taker |

## Verification
The chain is driven with several request patterns: two sparse requesters, all devices at once, a higher-priority request landing in the same cycle as an acknowledge, and a device that requests again in the cycle it is granted. Two of these checks separate a real positional chain from a design that serves requests in arrival order or that lets late requests join an acknowledge already under way. An acknowledge with nothing pending shows whether the pass-through to the end of the chain works. A reset taken while requests are pending shows that the pending flags are cleared and not merely hidden.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

  // Vector presented by the cell at a given chain position.
  function automatic logic [7:0] cell_vector(input logic [7:0] base, input int idx);
    return base + 8'(idx);
  endfunction

endpackage

// File: rtl/irq_chain_cell.sv
module irq_chain_cell #(
  parameter int VEC_W = 8,
  parameter logic [VEC_W-1:0] VEC_ID = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_i,
  input  logic             pi_i,
  output logic             po_o,
  output logic             win_o,
  output logic             pend_nxt_o,
  output logic             grant_o,
  output logic [VEC_W-1:0] vec_drive_o
);
  logic pend_q;
  logic grant_q;

  // The acknowledge is kept here when pending, otherwise handed down the chain.
  assign win_o       = pi_i & pend_q;
  assign po_o        = pi_i & ~pend_q;
  // A new request wins over the clear that comes with a grant.
  assign pend_nxt_o  = req_i | (pend_q & ~win_o);
  assign vec_drive_o = win_o ? VEC_ID : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      grant_q <= 1'b0;
    end else begin
      pend_q  <= pend_nxt_o;
      grant_q <= win_o;
    end
  end

  assign grant_o = grant_q;
endmodule

// File: rtl/irq_req_line.sv
module irq_req_line #(
  parameter int N_DEV = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_DEV-1:0] pend_nxt_i,
  output logic             irq_n_o
);
  logic irq_n_q;

  always_ff @(posedge clk) begin
    if (rst) irq_n_q <= 1'b1;
    else     irq_n_q <= ~(|pend_nxt_i);
  end

  assign irq_n_o = irq_n_q;
endmodule

// File: rtl/irq_vec_bus.sv
module irq_vec_bus #(
  parameter int N_DEV = 4,
  parameter int VEC_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_DEV*VEC_W-1:0] drive_i,
  input  logic [N_DEV-1:0]       win_i,
  input  logic                   chain_end_i,
  output logic [VEC_W-1:0]       vec_o,
  output logic                   vec_valid_o,
  output logic                   unclaimed_o
);
  logic [VEC_W-1:0] bus_or;
  logic [VEC_W-1:0] vec_q;
  logic             valid_q;
  logic             unc_q;

  // Wired-OR bus: at most one cell drives a non-zero value.
  always_comb begin
    bus_or = '0;
    for (int k = 0; k < N_DEV; k++) begin
      bus_or = bus_or | drive_i[k*VEC_W +: VEC_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q   <= '0;
      valid_q <= 1'b0;
      unc_q   <= 1'b0;
    end else begin
      vec_q   <= bus_or;
      valid_q <= |win_i;
      unc_q   <= chain_end_i;
    end
  end

  assign vec_o       = vec_q;
  assign vec_valid_o = valid_q;
  assign unclaimed_o = unc_q;
endmodule

// File: rtl/irq_daisy_arbiter.sv
module irq_daisy_arbiter
  import irq_chain_pkg::*;
#(
  parameter int         N_DEV    = 4,
  parameter logic [7:0] VEC_BASE = 8'h40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_DEV-1:0] dev_req_i,
  input  logic             ack_i,
  output logic             irq_n_o,
  output logic [N_DEV-1:0] grant_o,
  output logic [7:0]       vec_o,
  output logic             vec_valid_o,
  output logic             unclaimed_o
);
  localparam int VEC_W = 8;

  logic [N_DEV:0]             chain;
  logic [N_DEV-1:0]           win;
  logic [N_DEV-1:0]           pend_nxt;
  logic [N_DEV*VEC_W-1:0]     drive;

  assign chain[0] = ack_i;

  for (genvar g = 0; g < N_DEV; g++) begin : g_cell
    irq_chain_cell #(
      .VEC_W (VEC_W),
      .VEC_ID(cell_vector(VEC_BASE, g))
    ) u_cell (
      .clk        (clk),
      .rst        (rst),
      .req_i      (dev_req_i[g]),
      .pi_i       (chain[g]),
      .po_o       (chain[g+1]),
      .win_o      (win[g]),
      .pend_nxt_o (pend_nxt[g]),
      .grant_o    (grant_o[g]),
      .vec_drive_o(drive[g*VEC_W +: VEC_W])
    );
  end

  irq_req_line #(.N_DEV(N_DEV)) u_line (
    .clk       (clk),
    .rst       (rst),
    .pend_nxt_i(pend_nxt),
    .irq_n_o   (irq_n_o)
  );

  irq_vec_bus #(.N_DEV(N_DEV), .VEC_W(VEC_W)) u_bus (
    .clk        (clk),
    .rst        (rst),
    .drive_i    (drive),
    .win_i      (win),
    .chain_end_i(chain[N_DEV]),
    .vec_o      (vec_o),
    .vec_valid_o(vec_valid_o),
    .unclaimed_o(unclaimed_o)
  );
endmodule

// File: rtl/irq_daisy_checker.sv
module irq_daisy_checker #(
  parameter int N_DEV = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [N_DEV-1:0] dev_req_i,
  input logic             ack_i,
  input logic             irq_n_o,
  input logic [N_DEV-1:0] grant_o,
  input logic [7:0]       vec_o,
  input logic             vec_valid_o,
  input logic             unclaimed_o
);
  a_r4_grant_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_o));

  a_r5_valid_tracks_grant: assert property (@(posedge clk) disable iff (rst)
    vec_valid_o == (|grant_o));

  a_r5_idle_vector_zero: assert property (@(posedge clk) disable iff (rst)
    !vec_valid_o |-> vec_o == 8'h00);

  a_r8_unclaimed_no_grant: assert property (@(posedge clk) disable iff (rst)
    unclaimed_o |-> grant_o == '0);

  a_r10_no_grant_without_ack: assert property (@(posedge clk) disable iff (rst)
    !ack_i |=> grant_o == '0);

  a_r2_request_pulls_line: assert property (@(posedge clk) disable iff (rst)
    (|dev_req_i) |=> !irq_n_o);

  a_r8_unclaimed_needs_ack: assert property (@(posedge clk) disable iff (rst)
    !ack_i |=> !unclaimed_o);
endmodule

bind irq_daisy_arbiter irq_daisy_checker #(.N_DEV(N_DEV)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .dev_req_i  (dev_req_i),
  .ack_i      (ack_i),
  .irq_n_o    (irq_n_o),
  .grant_o    (grant_o),
  .vec_o      (vec_o),
  .vec_valid_o(vec_valid_o),
  .unclaimed_o(unclaimed_o)
);

// File: tb/irq_daisy_arbiter_tb.sv
module irq_daisy_arbiter_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] dev_req_i = '0;
  logic       ack_i = 1'b0;
  logic       irq_n_o;
  logic [3:0] grant_o;
  logic [7:0] vec_o;
  logic       vec_valid_o;
  logic       unclaimed_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_daisy_arbiter u_dut (
    .clk(clk), .rst(rst), .dev_req_i(dev_req_i), .ack_i(ack_i),
    .irq_n_o(irq_n_o), .grant_o(grant_o), .vec_o(vec_o),
    .vec_valid_o(vec_valid_o), .unclaimed_o(unclaimed_o)
  );

  // Entry: {req[3:0], ack, grant[3:0], vec[7:0], valid, irq_n, unclaimed}
  localparam int NSTEP = 13;
  localparam logic [19:0] TBL [NSTEP] = '{
    {4'b0000, 1'b0, 4'b0000, 8'h00, 1'b0, 1'b1, 1'b0}, // R3 idle line high
    {4'b1010, 1'b0, 4'b0000, 8'h00, 1'b0, 1'b0, 1'b0}, // R2 R10 latch, no grant
    {4'b0000, 1'b1, 4'b0010, 8'h41, 1'b1, 1'b0, 1'b0}, // R4 R5 dev1 first
    {4'b0000, 1'b1, 4'b1000, 8'h43, 1'b1, 1'b1, 1'b0}, // R6 R3 dev3 next, line high
    {4'b0000, 1'b1, 4'b0000, 8'h00, 1'b0, 1'b1, 1'b1}, // R8 nobody pending
    {4'b1111, 1'b0, 4'b0000, 8'h00, 1'b0, 1'b0, 1'b0}, // R2 all request
    {4'b0000, 1'b1, 4'b0001, 8'h40, 1'b1, 1'b0, 1'b0}, // R4 head wins
    {4'b0001, 1'b1, 4'b0010, 8'h41, 1'b1, 1'b0, 1'b0}, // R9 late dev0 skipped
    {4'b0000, 1'b1, 4'b0001, 8'h40, 1'b1, 1'b0, 1'b0}, // R9 dev0 served later
    {4'b0100, 1'b1, 4'b0100, 8'h42, 1'b1, 1'b0, 1'b0}, // R7 re-request at grant
    {4'b0000, 1'b1, 4'b0100, 8'h42, 1'b1, 1'b0, 1'b0}, // R7 dev2 again
    {4'b0000, 1'b1, 4'b1000, 8'h43, 1'b1, 1'b1, 1'b0}, // R6 R3 last one
    {4'b0000, 1'b0, 4'b0000, 8'h00, 1'b0, 1'b1, 1'b0}  // R10 quiet
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag, input logic [3:0] g, input logic [7:0] v,
                           input logic vv, input logic irqn, input logic unc);
    check({tag, " grant"},     32'(grant_o),     32'(g));
    check({tag, " vec"},       32'(vec_o),       32'(v));
    check({tag, " valid"},     32'(vec_valid_o), 32'(vv));
    check({tag, " irq_n"},     32'(irq_n_o),     32'(irqn));
    check({tag, " unclaimed"}, 32'(unclaimed_o), 32'(unc));
  endtask

  task automatic step(input logic [3:0] r, input logic a);
    @(negedge clk);
    dev_req_i = r;
    ack_i = a;
    @(posedge clk);
    #5;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5;
    check_all("R1 in reset", 4'b0000, 8'h00, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NSTEP; i++) begin
      step(TBL[i][19:16], TBL[i][15]);
      check_all($sformatf("table step %0d", i), TBL[i][14:11], TBL[i][10:3],
                TBL[i][2], TBL[i][1], TBL[i][0]);
    end

    // R1: reset while requests are pending clears them.
    step(4'b1111, 1'b0);
    check("R2 pending before reset irq_n", 32'(irq_n_o), 32'd0);
    @(negedge clk);
    dev_req_i = '0;
    rst = 1'b1;
    @(posedge clk);
    #5;
    check_all("R1 reset with pending", 4'b0000, 8'h00, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    step(4'b0000, 1'b1);
    check_all("R1 pending flushed by reset", 4'b0000, 8'h00, 1'b0, 1'b1, 1'b1);

    // R4 R5: lone lowest-priority device.
    step(4'b1000, 1'b0);
    step(4'b0000, 1'b1);
    check_all("R4 R5 lone tail device", 4'b1000, 8'h43, 1'b1, 1'b1, 1'b0);

    // R8: unclaimed is one cycle only.
    step(4'b0000, 1'b1);
    step(4'b0000, 1'b0);
    check("R8 unclaimed drops", 32'(unclaimed_o), 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule